// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital front end of a 12-bit voltage-output converter hung on an 8-bit microcontroller bus. The host writes the code in two byte-wide steps, a low byte and a high nibble, into holding registers selected by a 2-bit address. A third address holds a small control register. The 12-bit output latch that feeds the converter either follows the holding registers or keeps its value. The load pin and a control bit together decide which.

The bus strobes and the three mode pins (load, speed, power) arrive asynchronously. Each passes through a two-flop synchronizer into the system clock. A write is taken on the rising edge of the synchronized write strobe, and only while the synchronized select is low. The effective speed mode and the power-down state each combine a pin with a control-register bit. The host can therefore drive the converter from pins, from software, or from both.

Top module: `dac_parallel_front`

## Requirements
- R1: A register is written only on a rising edge of the write strobe `wr_n` while `sel_n` is low. A strobe edge with `sel_n` high changes no register.
- R2: Address 0 loads all 8 data bits into the low-byte holding register. Address 1 loads data bits 3:0 into the high-nibble holding register and ignores bits 7:4. The output code is {high nibble, low byte}.
- R3: A write to address 2 changes no register. The output code and both mode outputs stay as they were.
- R4: Address 3 writes the control register. Data bit 0 is the speed bit, bit 1 is the power-down bit and bit 2 is the load-enable bit. Bits 7:3 have no effect.
- R5: `fast_mode` is 0 only when the `speed_pin` input and the speed bit are both 0. Every other combination gives 1.
- R6: `powered_down` is 1 when `pwr_n` is low or the power-down bit is 1. It is 0 only when `pwr_n` is high and the bit is 0.
- R7: When `load_n` is low or the load-enable bit is 1, the latch is transparent. `dac_code` then shows the holding registers no later than one clock after they update.
- R8: When `load_n` is high and the load-enable bit is 0, `dac_code` holds its value while the holding registers are rewritten. The held value appears once the latch becomes transparent again.
- R9: Reset clears the holding registers, the control register and the output latch. With `speed_pin` low and `pwr_n` high, the outputs after reset are code 0, `fast_mode` 0 and `powered_down` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_data | input | 8 | Host data bus |
| bus_addr | input | 2 | Register address |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, write on rising edge |
| load_n | input | 1 | Active-low latch transparency pin |
| speed_pin | input | 1 | Speed pin, 1 selects fast |
| pwr_n | input | 1 | Active-low power-down pin |
| dac_code | output | 12 | Code driving the converter |
| fast_mode | output | 1 | Effective fast settling mode |
| powered_down | output | 1 | Effective power-down state |

## Verification
Two functions can meet in one clock: a holding-register write and the latch turning transparent. This happens when the load pin falls at the same instant the write strobe rises. Both pass through the same synchronizer depth, so the write lands in the same cycle that the latch first copies the older holding value. The bench drives exactly this alignment. It then requires that `dac_code` settles on the newly written value and not on the stale one.

// File: rtl/dac_parallel_front.sv
module dac_parallel_front #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       bus_data,
  input  logic [1:0]              bus_addr,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic                    load_n,
  input  logic                    speed_pin,
  input  logic                    pwr_n,
  output logic [DATA_W+NIB_W-1:0] dac_code,
  output logic                    fast_mode,
  output logic                    powered_down
);
  localparam int CODE_W = DATA_W + NIB_W;
  // synchronizer lanes: {speed, pwr_n, load_n, sel_n, wr_n}
  localparam logic [4:0] PIN_IDLE = 5'b01111;

  logic [4:0] s1, s2;
  logic       wr_d;
  logic [DATA_W-1:0] lo_q;
  logic [NIB_W-1:0]  hi_q;
  logic [2:0]        ctl_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= PIN_IDLE;
      s2   <= PIN_IDLE;
      wr_d <= 1'b1;
    end else begin
      s1   <= {speed_pin, pwr_n, load_n, sel_n, wr_n};
      s2   <= s1;
      wr_d <= s2[0];
    end

  wire wr_fire     = s2[0] & ~wr_d & ~s2[1];
  wire transparent = ~s2[2] | ctl_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
    end else if (wr_fire) begin
      case (bus_addr)
        2'd0:    lo_q  <= bus_data;
        2'd1:    hi_q  <= bus_data[NIB_W-1:0];
        2'd3:    ctl_q <= bus_data[2:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           code_q <= '0;
    else if (transparent) code_q <= {hi_q, lo_q};

  assign dac_code     = code_q;
  assign fast_mode    = s2[4] | ctl_q[0];
  assign powered_down = ~s2[3] | ctl_q[1];

  assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable({lo_q, hi_q, ctl_q}));
  assert_nibble_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == 2'd1) |=> hi_q == $past(bus_data[NIB_W-1:0]));
  assert_reserved_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == 2'd2) |=> $stable({lo_q, hi_q, ctl_q}));
  assert_ctl_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == 2'd3) |=> ctl_q == $past(bus_data[2:0]));
  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    transparent |=> dac_code == $past({hi_q, lo_q}));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !transparent |=> $stable(dac_code));
endmodule

// File: tb/dac_parallel_front_tb.sv
`timescale 1ns/1ps
module dac_parallel_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic [1:0] bus_addr = '0;
  logic sel_n = 1'b1, wr_n = 1'b1, load_n = 1'b1, speed_pin = 1'b0, pwr_n = 1'b1;
  logic [11:0] dac_code;
  logic fast_mode, powered_down;

  int checks = 0, errors = 0;
  logic [7:0] m_lo = '0;
  logic [3:0] m_hi = '0;
  logic [2:0] m_ctl = '0;
  logic [11:0] m_code = '0;

  always #2 clk = ~clk;

  dac_parallel_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .sel_n(sel_n), .wr_n(wr_n), .load_n(load_n), .speed_pin(speed_pin),
    .pwr_n(pwr_n), .dac_code(dac_code), .fast_mode(fast_mode),
    .powered_down(powered_down));

  function automatic logic exp_fast(logic pin, logic bit_v);
    return pin | bit_v;
  endfunction
  function automatic logic exp_pd(logic pin_n, logic bit_v);
    return !pin_n | bit_v;
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle_model();
    if (!load_n || m_ctl[2]) m_code = {m_hi, m_lo};
  endtask

  task automatic check_all(string code_req);
    check(code_req, dac_code, m_code);
    check("R5 fast_mode", {11'd0, fast_mode}, {11'd0, exp_fast(speed_pin, m_ctl[0])});
    check("R6 powered_down", {11'd0, powered_down}, {11'd0, exp_pd(pwr_n, m_ctl[1])});
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d, logic sel, logic drop_ld);
    @(negedge clk);
    bus_addr = a; bus_data = d; sel_n = sel; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    if (drop_ld) load_n = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
    if (!sel) begin
      case (a)
        2'd0: m_lo = d;
        2'd1: m_hi = d[3:0];
        2'd3: m_ctl = d[2:0];
        default: ;
      endcase
    end
    settle_model();
  endtask

  task automatic set_pins(logic ld, logic sp, logic pw);
    @(negedge clk);
    load_n = ld; speed_pin = sp; pwr_n = pw;
    repeat (4) @(negedge clk);
    settle_model();
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5613));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset code", dac_code, 12'h000);
    check("R9 reset fast", {11'd0, fast_mode}, 12'd0);
    check("R9 reset pd", {11'd0, powered_down}, 12'd0);

    // R8: hold while load pin high and bit clear
    bus_write(2'd0, 8'hA5, 1'b0, 1'b0);
    bus_write(2'd1, 8'hF7, 1'b0, 1'b0);
    check("R8 held", dac_code, 12'h000);
    // R7: control load-enable bit opens the latch; R2 upper nibble bits dropped
    bus_write(2'd3, 8'h04, 1'b0, 1'b0);
    check("R7 ctl transparent", dac_code, 12'h7A5);
    check("R2 nibble", dac_code, m_code);
    bus_write(2'd3, 8'h00, 1'b0, 1'b0);
    // R1: strobe without select
    bus_write(2'd0, 8'h3C, 1'b1, 1'b0);
    set_pins(1'b0, 1'b0, 1'b1);
    check("R1 deselected write ignored", dac_code, 12'h7A5);
    // R3: reserved address
    bus_write(2'd2, 8'hFF, 1'b0, 1'b0);
    check_all("R3 reserved");
    check("R3 reserved code", dac_code, 12'h7A5);
    // R4: upper control bits inert
    bus_write(2'd3, 8'hF8, 1'b0, 1'b0);
    check_all("R4 upper ctl bits");
    // truth tables R5 R6 R7/R8
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 2; b++) begin
        set_pins(1'b1, p[0], !p[0]);
        bus_write(2'd3, {5'd0, b[0], b[0], b[0]}, 1'b0, 1'b0);
        bus_write(2'd0, 8'(p * 16 + b * 3 + 1), 1'b0, 1'b0);
        check_all("R5 R6 R7 R8 table, load pin high");
        set_pins(1'b0, p[0], !p[0]);
        check_all("R7 table, load pin low");
      end
    // same-cycle: write landing as latch opens
    bus_write(2'd3, 8'h00, 1'b0, 1'b0);
    set_pins(1'b1, 1'b0, 1'b1);
    bus_write(2'd0, 8'h5E, 1'b0, 1'b1);
    check("R7 write with load edge", dac_code, {m_hi, 8'h5E});
    // random
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(9) < 6)
        bus_write(2'($urandom_range(3)), 8'($urandom), ($urandom_range(4) == 0), 1'b0);
      else
        set_pins(1'($urandom), 1'($urandom), ($urandom_range(3) != 0));
      check_all("R7/R8 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule